// File: doc/BRIEF.md
# Streaming Convolution Layer Engine

This block computes one layer of a convolutional network. A host first writes the layer inputs through two byte-wide write ports. One port holds the 8-bit unsigned input maps, and the other holds the 8-bit signed 3x3 kernels. The host then pulses `start`. For each output channel, the engine slides a 3x3 window over an input map that is padded with a one-pixel ring of zeros. It multiplies and accumulates across every input channel. It then clips negative sums to zero and rescales the result to an 8-bit code using constants fixed at build time. Finally it reduces each 2x2 group of these codes to its maximum.

The engine emits pooled pixels through a write-style output port as it produces them. The output is channel-major, and row-major within each channel. A one-cycle `done` pulse marks the end of the layer. The engine uses a single multiply-accumulate lane, and it spends one cycle per kernel tap. The number of input channels, output channels and the map side are all parameters.

Top module: `conv_layer_engine`

## Requirements
- R1: After reset, `busy`, `done` and `out_valid` are all low.
- R2: The input map byte for channel n, row r and column c lives at `fm_addr = n*SIDE*SIDE + r*SIDE + c`. The kernel byte for output channel m, input channel n, row offset dy and column offset dx (each in -1..1) lives at `wt_addr = (m*N_IN + n)*9 + 3*(dy+1) + (dx+1)`. Any window tap that falls outside the map contributes zero, so the convolution result is SIDE x SIDE.
- R3: Each convolution sum for output channel m adds the products of all N_IN input channels, with each channel using its own kernel.
- R4: A negative convolution sum is replaced by zero before rescaling, so it yields the code ZERO_PT.
- R5: A non-negative sum s becomes floor(s*SCALE / 2^SHIFT) + ZERO_PT, and any result above 255 is clipped to 255.
- R6: Pooled pixel (pr, pc) is the largest of the four rescaled codes at rows 2pr..2pr+1 and columns 2pc..2pc+1. The pooled side is floor(SIDE/2).
- R7: A run makes exactly M_OUT*P*P writes, where P = floor(SIDE/2). Write addresses are `m*P*P + pr*P + pc` and appear in ascending order.
- R8: `done` is high for exactly one cycle, in the cycle after the final write. `busy` is already low in the cycle of the final write.
- R9: Writes to either load port while `busy` is high change no stored byte.
- R10: A `start` seen while idle raises `busy` in the next cycle. A `start` seen while busy neither restarts nor extends the run.
- R11: If the edge that samples `start` is counted as cycle 0, write k (counting from 0) is visible in cycle 36*N_IN*(k+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a layer run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fm_we | input | 1 | Input map byte write strobe |
| fm_addr | input | FM_AW | Input map byte address |
| fm_wdata | input | 8 | Input map byte, unsigned |
| wt_we | input | 1 | Kernel byte write strobe |
| wt_addr | input | WT_AW | Kernel byte address |
| wt_wdata | input | 8 | Kernel byte, two's complement |
| out_valid | output | 1 | Pooled pixel write strobe |
| out_addr | output | OUT_AW | Pooled pixel address |
| out_data | output | 8 | Pooled pixel code |

## Verification
The assertions assume the following about the inputs:
- Load addresses stay below the map and kernel depths.
- ZERO_PT is no larger than 255.
- Each pooled pixel takes more than one cycle, so two writes are never adjacent.

The bench respects these assumptions. It addresses only valid bytes and loads only between runs, except in one scenario. That scenario deliberately writes both stores and pulses `start` in the middle of a run, and then compares the results against the data loaded before the run.

// File: rtl/cle_pkg.sv
package cle_pkg;

  typedef enum logic {CLE_IDLE, CLE_RUN} cle_state_e;

  // Clip a sign-extended sum at zero
  function automatic logic signed [47:0] cle_relu(input logic signed [47:0] acc);
    return acc[47] ? 48'sd0 : acc;
  endfunction

  // Scale, shift right, add offset, saturate to one byte
  function automatic logic [7:0] cle_requant(input logic signed [47:0] acc,
                                             input int scale, input int shift, input int zp);
    logic [63:0] mag;
    logic [63:0] scaled;
    mag = acc[47] ? 64'd0 : {16'd0, acc};
    scaled = (mag * 64'(scale)) >> shift;
    scaled = scaled + 64'(zp);
    return (scaled > 64'd255) ? 8'hFF : scaled[7:0];
  endfunction

  function automatic logic [7:0] cle_max8(input logic [7:0] a, input logic [7:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cle_bytemem.sv
module cle_bytemem #(
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'd0;
endmodule

// File: rtl/cle_walker.sv
module cle_walker
  import cle_pkg::*;
#(
  parameter int N_IN   = 2,
  parameter int M_OUT  = 2,
  parameter int SIDE   = 4,
  parameter int FM_AW  = 5,
  parameter int WT_AW  = 6,
  parameter int OUT_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [FM_AW-1:0]  fm_raddr,
  output logic [WT_AW-1:0]  wt_raddr,
  output logic              tap_pad,
  output logic              tap_first,
  output logic              tap_last,
  output logic [1:0]        win_q,
  output logic              win_last,
  output logic              job_last,
  output logic [OUT_AW-1:0] pix_addr
);
  localparam int PS = SIDE / 2;
  localparam int NW = (N_IN  > 1) ? $clog2(N_IN)  : 1;
  localparam int MW = (M_OUT > 1) ? $clog2(M_OUT) : 1;
  localparam int PW = (PS    > 1) ? $clog2(PS)    : 1;
  localparam logic [NW-1:0] N_LAST = NW'(N_IN - 1);
  localparam logic [MW-1:0] M_LAST = MW'(M_OUT - 1);
  localparam logic [PW-1:0] P_LAST = PW'(PS - 1);

  cle_state_e    st;
  logic [1:0]    k_x, k_y, q_c;
  logic [NW-1:0] n_c;
  logic [PW-1:0] pc_c, pr_c;
  logic [MW-1:0] m_c;
  int            tap_row, tap_col;

  assign busy      = (st == CLE_RUN);
  assign win_q     = q_c;
  assign tap_first = busy && (n_c == '0) && (k_x == 2'd0) && (k_y == 2'd0);
  assign tap_last  = busy && (n_c == N_LAST) && (k_x == 2'd2) && (k_y == 2'd2);
  assign win_last  = tap_last && (q_c == 2'd3);
  assign job_last  = win_last && (pc_c == P_LAST) && (pr_c == P_LAST) && (m_c == M_LAST);

  // Tap coordinates in the unpadded map
  always_comb begin
    tap_row  = 2 * int'(pr_c) + int'(q_c[1]) + int'(k_y) - 1;
    tap_col  = 2 * int'(pc_c) + int'(q_c[0]) + int'(k_x) - 1;
    tap_pad  = (tap_row < 0) || (tap_row >= SIDE) || (tap_col < 0) || (tap_col >= SIDE);
    fm_raddr = tap_pad ? '0 : FM_AW'(int'(n_c) * SIDE * SIDE + tap_row * SIDE + tap_col);
    wt_raddr = WT_AW'((int'(m_c) * N_IN + int'(n_c)) * 9 + int'(k_y) * 3 + int'(k_x));
    pix_addr = OUT_AW'(int'(m_c) * PS * PS + int'(pr_c) * PS + int'(pc_c));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= CLE_IDLE;
      k_x <= '0; k_y <= '0; n_c <= '0; q_c <= '0;
      pc_c <= '0; pr_c <= '0; m_c <= '0;
    end else if (st == CLE_IDLE) begin
      if (start) begin
        st <= CLE_RUN;
        k_x <= '0; k_y <= '0; n_c <= '0; q_c <= '0;
        pc_c <= '0; pr_c <= '0; m_c <= '0;
      end
    end else begin
      if (k_x != 2'd2) k_x <= k_x + 2'd1;
      else begin
        k_x <= '0;
        if (k_y != 2'd2) k_y <= k_y + 2'd1;
        else begin
          k_y <= '0;
          if (n_c != N_LAST) n_c <= n_c + 1'b1;
          else begin
            n_c <= '0;
            q_c <= q_c + 2'd1;
            if (q_c == 2'd3) begin
              if (pc_c != P_LAST) pc_c <= pc_c + 1'b1;
              else begin
                pc_c <= '0;
                if (pr_c != P_LAST) pr_c <= pr_c + 1'b1;
                else begin
                  pr_c <= '0;
                  if (m_c != M_LAST) m_c <= m_c + 1'b1;
                  else st <= CLE_IDLE;
                end
              end
            end
          end
        end
      end
    end
  end

  AST_START_ENTERS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R10
  AST_RUN_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !job_last) |=> busy); // R10
  AST_TOP_EDGE_PADDED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pr_c == '0 && !q_c[1] && k_y == 2'd0) |-> tap_pad); // R2
endmodule

// File: rtl/cle_mac_pool.sv
module cle_mac_pool
  import cle_pkg::*;
#(
  parameter int ACC_W   = 22,
  parameter int OUT_AW  = 3,
  parameter int SCALE   = 5,
  parameter int SHIFT   = 6,
  parameter int ZERO_PT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              tap_pad,
  input  logic              tap_first,
  input  logic              tap_last,
  input  logic [1:0]        win_q,
  input  logic              win_last,
  input  logic              job_last,
  input  logic [OUT_AW-1:0] pix_addr,
  input  logic [7:0]        pix,
  input  logic [7:0]        wt,
  output logic              out_valid,
  output logic [OUT_AW-1:0] out_addr,
  output logic [7:0]        out_data,
  output logic              done
);
  logic signed [16:0]    prod;
  logic signed [ACC_W-1:0] acc_q, acc_sum;
  logic signed [47:0]    acc_wide, relu_acc;
  logic [7:0]            code, pool_q, pool_next;
  logic                  last_q;

  assign prod      = $signed({1'b0, (tap_pad ? 8'd0 : pix)}) * $signed(wt);
  assign acc_sum   = (tap_first ? '0 : acc_q) + {{(ACC_W-17){prod[16]}}, prod};
  assign acc_wide  = {{(48-ACC_W){acc_sum[ACC_W-1]}}, acc_sum};
  assign relu_acc  = cle_relu(acc_wide);
  assign code      = cle_requant(relu_acc, SCALE, SHIFT, ZERO_PT);
  assign pool_next = (win_q == 2'd0) ? code : cle_max8(pool_q, code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0; pool_q <= '0;
      out_valid <= 1'b0; out_addr <= '0; out_data <= '0;
      last_q <= 1'b0; done <= 1'b0;
    end else begin
      if (busy) acc_q <= acc_sum;
      if (tap_last) pool_q <= pool_next;
      out_valid <= win_last;
      if (win_last) begin
        out_addr <= pix_addr;
        out_data <= pool_next;
      end
      last_q <= job_last;
      done   <= last_q;
    end
  end

  AST_NEG_SUM_TO_ZP: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_last && acc_sum[ACC_W-1]) |-> (code == 8'(ZERO_PT))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid)); // R8
  AST_WRITE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R11
endmodule

// File: rtl/conv_layer_engine.sv
module conv_layer_engine #(
  parameter int N_IN    = 2,
  parameter int M_OUT   = 2,
  parameter int SIDE    = 4,
  parameter int SCALE   = 5,
  parameter int SHIFT   = 6,
  parameter int ZERO_PT = 3,
  localparam int FM_DEPTH  = N_IN * SIDE * SIDE,
  localparam int WT_DEPTH  = M_OUT * N_IN * 9,
  localparam int OUT_DEPTH = M_OUT * (SIDE / 2) * (SIDE / 2),
  localparam int FM_AW  = (FM_DEPTH  > 1) ? $clog2(FM_DEPTH)  : 1,
  localparam int WT_AW  = (WT_DEPTH  > 1) ? $clog2(WT_DEPTH)  : 1,
  localparam int OUT_AW = (OUT_DEPTH > 1) ? $clog2(OUT_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic              fm_we,
  input  logic [FM_AW-1:0]  fm_addr,
  input  logic [7:0]        fm_wdata,
  input  logic              wt_we,
  input  logic [WT_AW-1:0]  wt_addr,
  input  logic [7:0]        wt_wdata,
  output logic              out_valid,
  output logic [OUT_AW-1:0] out_addr,
  output logic [7:0]        out_data
);
  localparam int ACC_W = 17 + $clog2(9 * N_IN);

  logic [FM_AW-1:0]  fm_raddr;
  logic [WT_AW-1:0]  wt_raddr;
  logic [7:0]        fm_rdata, wt_rdata;
  logic              tap_pad, tap_first, tap_last, win_last, job_last;
  logic [1:0]        win_q;
  logic [OUT_AW-1:0] pix_addr;

  cle_bytemem #(.DEPTH(FM_DEPTH), .AW(FM_AW)) u_fm (
    .clk(clk), .we(fm_we && !busy), .waddr(fm_addr), .wdata(fm_wdata),
    .raddr(fm_raddr), .rdata(fm_rdata));

  cle_bytemem #(.DEPTH(WT_DEPTH), .AW(WT_AW)) u_wt (
    .clk(clk), .we(wt_we && !busy), .waddr(wt_addr), .wdata(wt_wdata),
    .raddr(wt_raddr), .rdata(wt_rdata));

  cle_walker #(.N_IN(N_IN), .M_OUT(M_OUT), .SIDE(SIDE),
               .FM_AW(FM_AW), .WT_AW(WT_AW), .OUT_AW(OUT_AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .fm_raddr(fm_raddr), .wt_raddr(wt_raddr), .tap_pad(tap_pad),
    .tap_first(tap_first), .tap_last(tap_last), .win_q(win_q),
    .win_last(win_last), .job_last(job_last), .pix_addr(pix_addr));

  cle_mac_pool #(.ACC_W(ACC_W), .OUT_AW(OUT_AW), .SCALE(SCALE),
                 .SHIFT(SHIFT), .ZERO_PT(ZERO_PT)) u_dp (
    .clk(clk), .rst_n(rst_n), .busy(busy), .tap_pad(tap_pad),
    .tap_first(tap_first), .tap_last(tap_last), .win_q(win_q),
    .win_last(win_last), .job_last(job_last), .pix_addr(pix_addr),
    .pix(fm_rdata), .wt(wt_rdata), .out_valid(out_valid),
    .out_addr(out_addr), .out_data(out_data), .done(done));
endmodule

// File: tb/sim_conv_layer_engine.sv
`timescale 1ns/1ps
module sim_conv_layer_engine;
  localparam int N = 2, M = 2, L = 4, SC = 5, SH = 6, ZP = 3;
  localparam int P = L / 2;
  localparam int FMD = N * L * L, WTD = M * N * 9, OUTN = M * P * P;
  localparam int PER = 36 * N;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic fm_we = 1'b0, wt_we = 1'b0;
  logic [4:0] fm_addr = '0;
  logic [5:0] wt_addr = '0;
  logic [7:0] fm_wdata = '0, wt_wdata = '0;
  logic busy, done, out_valid;
  logic [2:0] out_addr;
  logic [7:0] out_data;

  int n_run = 0, n_fail = 0;
  int fm_m [FMD];
  int wt_m [WTD];

  always #2.5 clk = ~clk;

  conv_layer_engine #(.N_IN(N), .M_OUT(M), .SIDE(L), .SCALE(SC), .SHIFT(SH), .ZERO_PT(ZP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fm_we(fm_we), .fm_addr(fm_addr), .fm_wdata(fm_wdata),
    .wt_we(wt_we), .wt_addr(wt_addr), .wt_wdata(wt_wdata),
    .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_pix(int m, int pr, int pc);
    int best = -1;
    for (int dy = 0; dy < 2; dy++)
      for (int dx = 0; dx < 2; dx++) begin
        int y = 2 * pr + dy, x = 2 * pc + dx;
        longint s = 0, v;
        for (int ch = 0; ch < N; ch++)
          for (int i = -1; i <= 1; i++)
            for (int j = -1; j <= 1; j++)
              if (y + i >= 0 && y + i < L && x + j >= 0 && x + j < L)
                s += fm_m[ch * L * L + (y + i) * L + (x + j)] *
                     wt_m[(m * N + ch) * 9 + (i + 1) * 3 + (j + 1)];
        if (s < 0) s = 0;
        v = (s * SC) / (1 << SH) + ZP;
        if (v > 255) v = 255;
        if (int'(v) > best) best = int'(v);
      end
    return best;
  endfunction

  task automatic load_all();
    for (int i = 0; i < FMD; i++) begin
      @(posedge clk); #1;
      fm_we = 1'b1; fm_addr = 5'(i); fm_wdata = 8'(fm_m[i]);
    end
    for (int i = 0; i < WTD; i++) begin
      @(posedge clk); #1;
      fm_we = 1'b0; wt_we = 1'b1; wt_addr = 6'(i); wt_wdata = 8'(wt_m[i]);
    end
    @(posedge clk); #1;
    wt_we = 1'b0;
  endtask

  task automatic run_check(input string req, input bit inject);
    int got_a [OUTN];
    int got_d [OUTN];
    int got_c [OUTN];
    int nw = 0, done_cnt = 0, done_cyc = -1;
    @(posedge clk); #1; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    chk(busy === 1'b1, "R10 busy after start", int'(busy), 1);
    for (int cyc = 1; cyc <= PER * OUTN + 4; cyc++) begin
      @(posedge clk); #1;
      if (out_valid) begin
        if (nw < OUTN) begin
          got_a[nw] = int'(out_addr); got_d[nw] = int'(out_data); got_c[nw] = cyc;
        end
        nw++;
        if (nw == OUTN) chk(busy === 1'b0, "R8 busy low at final write", int'(busy), 0);
      end
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (inject && cyc == 5) begin
        fm_we = 1'b1; fm_addr = 5'd0; fm_wdata = 8'd200;
        wt_we = 1'b1; wt_addr = 6'd0; wt_wdata = 8'h9C; start = 1'b1;
      end
      if (inject && cyc == 6) begin
        fm_we = 1'b0; wt_we = 1'b0; start = 1'b0;
      end
    end
    chk(nw == OUTN, "R7 write count", nw, OUTN);
    for (int k = 0; k < OUTN && k < nw; k++) begin
      int m = k / (P * P), pr = (k % (P * P)) / P, pc = k % P;
      chk(got_a[k] == k, "R7 write order", got_a[k], k);
      chk(got_d[k] == model_pix(m, pr, pc), req, got_d[k], model_pix(m, pr, pc));
      chk(got_c[k] == PER * (k + 1), "R11 write cycle", got_c[k], PER * (k + 1));
    end
    chk(done_cnt == 1, "R8 done pulse count", done_cnt, 1);
    chk(done_cyc == PER * OUTN + 1, "R8 done cycle", done_cyc, PER * OUTN + 1);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk(done === 1'b0, "R1 done", int'(done), 0);
    chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
  endtask

  task automatic t_mixed();
    for (int i = 0; i < FMD; i++) fm_m[i] = (i * 37 + 11) % 256;
    for (int i = 0; i < WTD; i++) wt_m[i] = ((i * 29 + 5) % 61) - 30;
    load_all();
    run_check("R3 R5 R6 mixed pattern", 1'b0);
  endtask

  task automatic t_relu();
    for (int i = 0; i < FMD; i++) fm_m[i] = (i % 200) + 1;
    for (int i = 0; i < WTD; i++) wt_m[i] = -((i % 9) + 1);
    load_all();
    run_check("R4 negative sums give zero point", 1'b0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < FMD; i++) fm_m[i] = 255;
    for (int i = 0; i < WTD; i++) wt_m[i] = 127;
    load_all();
    run_check("R5 saturation to 255", 1'b0);
  endtask

  task automatic t_corner();
    for (int i = 0; i < FMD; i++) fm_m[i] = 0;
    fm_m[0] = 90; fm_m[L * L - 1] = 150; fm_m[L * L + L - 1] = 60;
    for (int i = 0; i < WTD; i++) wt_m[i] = (i % 9) * 7 + 1;
    load_all();
    run_check("R2 zero padding at edges", 1'b0);
  endtask

  task automatic t_channels();
    for (int i = 0; i < FMD; i++) fm_m[i] = (i < L * L) ? 0 : (i % 50) * 3;
    for (int i = 0; i < WTD; i++) wt_m[i] = ((i / 9) % N == 0) ? 100 : (i % 5) - 1;
    load_all();
    run_check("R3 second channel only", 1'b0);
  endtask

  task automatic t_busy_ignore();
    for (int i = 0; i < FMD; i++) fm_m[i] = (i * 53 + 7) % 256;
    for (int i = 0; i < WTD; i++) wt_m[i] = ((i * 17 + 3) % 41) - 15;
    load_all();
    run_check("R9 R10 loads and start ignored while busy", 1'b1);
    run_check("R9 stores unchanged on rerun", 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_mixed();
    t_relu();
    t_saturate();
    t_corner();
    t_channels();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule